// File: doc/BRIEF.md
# Scan Access Lock Controller

This block decides whether the scan path of a cipher engine can be used. It has two modes. In the open mode, scan shifting is allowed. The engine runs on a mirror key held in a small shift register that is part of the scan path, so the real secret is never near the test logic. In the locked mode, scan input and scan output are both cut off and the engine runs on the secret key.

A test-controller instruction moves the block from open to locked. The controller presents an instruction value together with an update strobe. The move is one way: once the block is locked, the only thing that makes it open again is the synchronous power-on reset. Both modes allow normal operation of the engine. Only the open mode allows test shifting.

The three mode outputs come straight from flip-flops. The key multiplexer, the scan-data gates and the shift-enable gate are driven by those same flip-flops. This means the key selection and the scan enables always change on the same clock edge.

Top module: `scan_guard_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, the block is open. In that state `scan_in_en`=1, `scan_out_en`=1 and `key_load_sel`=0, and the mirror key register holds all zeros, so `eng_key` is 0.
- R2: In the locked mode, `scan_in_en`=0, `scan_out_en`=0 and `key_load_sel`=1.
- R3: When `ir_update` is 1 on a clock edge and `ir_value` equals the lock code (default 4'b1010), the locked outputs appear right after that edge. Any other value with the strobe does not change the mode, and neither does the lock code without the strobe.
- R4: Once locked, the block stays locked whatever `ir_value`, `ir_update`, `scan_shift`, `scan_si` or `eng_so` do.
- R5: Only `rst` returns a locked block to the open mode. After that, scan shifting of the mirror key works again.
- R6: `eng_key` equals the mirror key register while open and `secret_key` while locked. It switches on the same edge as the mode outputs, so `scan_in_en` and `key_load_sel` are never 1 together.
- R7: While locked, `scan_so` is 0 whatever `eng_so` is. While open, `scan_so` equals `eng_so`.
- R8: While locked, the scan input is ignored. `eng_shift` and `eng_si` stay 0, and the mirror key register does not change.
- R9: While open with `scan_shift`=1, each clock edge shifts the mirror key register one place toward its MSB and loads `scan_si` into bit 0. `eng_si` presents the register's MSB, and `eng_shift` follows `scan_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ir_value | input | IR_W | Instruction value from the test controller |
| ir_update | input | 1 | Instruction update strobe |
| scan_shift | input | 1 | Scan shift request from the test port |
| scan_si | input | 1 | Scan serial input pin |
| eng_so | input | 1 | Serial output of the engine's scan chain |
| secret_key | input | KEY_W | Secret key from hardwired or protected storage |
| scan_in_en | output | 1 | Scan-in enable (1 while open) |
| scan_out_en | output | 1 | Scan-out enable (1 while open) |
| key_load_sel | output | 1 | Secret-key select (1 while locked) |
| eng_shift | output | 1 | Gated shift enable to the engine chain |
| eng_si | output | 1 | Gated serial data into the engine chain |
| scan_so | output | 1 | Gated scan serial output pin |
| eng_key | output | KEY_W | Key presented to the cipher engine |

## Verification
The mode outputs and the key select come from registers. The bench applies each instruction and strobe on a falling edge and samples one nanosecond after the next rising edge, where the new mode must already show. A mirror-key shift is likewise visible one edge after its `scan_shift` cycle. After eight shifts the whole key is read at `eng_key`. The gated `scan_so`, `eng_si` and `eng_shift` outputs are combinational from the mode flops and the current inputs, so the bench checks them in the same post-edge sample as the mode.

// File: rtl/scan_guard_pkg.sv
package scan_guard_pkg;
  typedef enum logic {
    MODE_OPEN   = 1'b0,
    MODE_LOCKED = 1'b1
  } guard_mode_e;

  localparam int unsigned DEF_IR_W  = 4;
  localparam int unsigned DEF_KEY_W = 8;
endpackage

// File: rtl/sg_cmd_decode.sv
module sg_cmd_decode #(
  parameter int unsigned     IR_W      = 4,
  parameter logic [IR_W-1:0] LOCK_CODE = 4'b1010
) (
  input  logic [IR_W-1:0] ir_value,
  input  logic            ir_update,
  output logic            lock_req
);
  // A lock request is an update strobe carrying the lock opcode.
  always_comb begin
    lock_req = ir_update && (ir_value == LOCK_CODE);
  end
endmodule

// File: rtl/sg_mode_fsm.sv
module sg_mode_fsm
  import scan_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lock_req,
  output logic in_en,
  output logic out_en,
  output logic key_sel
);
  guard_mode_e mode_q;
  logic        in_en_q;
  logic        out_en_q;
  logic        key_sel_q;

  // No edge leaves MODE_LOCKED except reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_OPEN;
      in_en_q   <= 1'b1;
      out_en_q  <= 1'b1;
      key_sel_q <= 1'b0;
    end else if (lock_req) begin
      mode_q    <= MODE_LOCKED;
      in_en_q   <= 1'b0;
      out_en_q  <= 1'b0;
      key_sel_q <= 1'b1;
    end
  end

  assign in_en   = in_en_q;
  assign out_en  = out_en_q;
  assign key_sel = key_sel_q;

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LOCKED) |=> (mode_q == MODE_LOCKED));

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    lock_req |=> (key_sel_q && !in_en_q && !out_en_q));

  // R3
  no_spurious_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_req && (mode_q == MODE_OPEN)) |=> (in_en_q && out_en_q && !key_sel_q));

  // R6
  scan_key_excl_chk: assert property (@(posedge clk) disable iff (rst)
    in_en_q |-> !key_sel_q);
endmodule

// File: rtl/sg_mirror_reg.sv
module sg_mirror_reg #(
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_ok,
  input  logic             si,
  output logic [KEY_W-1:0] mirror_q,
  output logic             msb
);
  localparam int unsigned TOP = KEY_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mirror_q <= '0;
    end else if (shift_ok) begin
      mirror_q <= {mirror_q[TOP-1:0], si};
    end
  end

  assign msb = mirror_q[TOP];

  // R8
  mirror_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_ok |=> $stable(mirror_q));

  // R9
  mirror_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift_ok |=> (mirror_q[0] == $past(si)));
endmodule

// File: rtl/sg_path_gate.sv
module sg_path_gate #(
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic             out_en,
  input  logic             key_sel,
  input  logic             scan_shift,
  input  logic             mirror_msb,
  input  logic             eng_so,
  input  logic [KEY_W-1:0] mirror_key,
  input  logic [KEY_W-1:0] secret_key,
  output logic             eng_shift,
  output logic             eng_si,
  output logic             scan_so,
  output logic [KEY_W-1:0] eng_key
);
  always_comb begin
    eng_shift = scan_shift & in_en;
    eng_si    = mirror_msb & in_en;
    scan_so   = eng_so & out_en;
    eng_key   = key_sel ? secret_key : mirror_key;
  end

  // R7
  so_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> (scan_so == 1'b0));

  // R8
  si_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_en |-> (!eng_si && !eng_shift));

  // R6
  key_secret_chk: assert property (@(posedge clk) disable iff (rst)
    key_sel |-> (eng_key == secret_key));
endmodule

// File: rtl/scan_guard_ctrl.sv
module scan_guard_ctrl
  import scan_guard_pkg::*;
#(
  parameter int unsigned     IR_W      = DEF_IR_W,
  parameter int unsigned     KEY_W     = DEF_KEY_W,
  parameter logic [IR_W-1:0] LOCK_CODE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IR_W-1:0]  ir_value,
  input  logic             ir_update,
  input  logic             scan_shift,
  input  logic             scan_si,
  input  logic             eng_so,
  input  logic [KEY_W-1:0] secret_key,
  output logic             scan_in_en,
  output logic             scan_out_en,
  output logic             key_load_sel,
  output logic             eng_shift,
  output logic             eng_si,
  output logic             scan_so,
  output logic [KEY_W-1:0] eng_key
);
  logic             lock_req;
  logic             in_en;
  logic             out_en;
  logic             key_sel;
  logic [KEY_W-1:0] mirror_key;
  logic             mirror_msb;

  sg_cmd_decode #(.IR_W(IR_W), .LOCK_CODE(LOCK_CODE)) u_dec (
    .ir_value (ir_value),
    .ir_update(ir_update),
    .lock_req (lock_req)
  );

  sg_mode_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .lock_req(lock_req),
    .in_en   (in_en),
    .out_en  (out_en),
    .key_sel (key_sel)
  );

  sg_mirror_reg #(.KEY_W(KEY_W)) u_mirror (
    .clk     (clk),
    .rst     (rst),
    .shift_ok(scan_shift & in_en),
    .si      (scan_si),
    .mirror_q(mirror_key),
    .msb     (mirror_msb)
  );

  sg_path_gate #(.KEY_W(KEY_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .in_en     (in_en),
    .out_en    (out_en),
    .key_sel   (key_sel),
    .scan_shift(scan_shift),
    .mirror_msb(mirror_msb),
    .eng_so    (eng_so),
    .mirror_key(mirror_key),
    .secret_key(secret_key),
    .eng_shift (eng_shift),
    .eng_si    (eng_si),
    .scan_so   (scan_so),
    .eng_key   (eng_key)
  );

  assign scan_in_en   = in_en;
  assign scan_out_en  = out_en;
  assign key_load_sel = key_sel;
endmodule

// File: tb/scan_guard_ctrl_test.sv
module scan_guard_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ir_value = '0;
  logic       ir_update = 1'b0;
  logic       scan_shift = 1'b0;
  logic       scan_si = 1'b0;
  logic       eng_so = 1'b0;
  logic [7:0] secret_key = 8'h3C;
  logic       scan_in_en, scan_out_en, key_load_sel, eng_shift, eng_si, scan_so;
  logic [7:0] eng_key;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  scan_guard_ctrl uut (
    .clk(clk), .rst(rst), .ir_value(ir_value), .ir_update(ir_update),
    .scan_shift(scan_shift), .scan_si(scan_si), .eng_so(eng_so),
    .secret_key(secret_key), .scan_in_en(scan_in_en), .scan_out_en(scan_out_en),
    .key_load_sel(key_load_sel), .eng_shift(eng_shift), .eng_si(eng_si),
    .scan_so(scan_so), .eng_key(eng_key)
  );

  // Vector layout: [11:8] ir, [7] update, [6] shift, [5] si, [4] eng_so,
  // [3] exp scan_in_en, [2] exp scan_out_en, [1] exp key_load_sel, [0] exp scan_so
  localparam logic [11:0] VEC [8] = '{
    12'b0000_0001_1101,  // R3 idle, open
    12'b1010_0001_1101,  // R3 lock code without strobe
    12'b1011_1000_1100,  // R3 wrong code with strobe
    12'b0101_1111_1101,  // R3 wrong code while shifting
    12'b1010_1001_0010,  // R3 R2 lock taken at this edge
    12'b0000_1111_0010,  // R4 R7 stays locked
    12'b1111_1101_0010,  // R4 R7
    12'b1010_1111_0010   // R4 repeated lock code
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_idle();
    @(negedge clk);
    ir_value = '0; ir_update = 1'b0; scan_shift = 1'b0; scan_si = 1'b0;
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      scan_shift = 1'b1; scan_si = b[i];
      tick();
    end
    drive_idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick(); tick();
    @(negedge clk);
    rst = 1'b0;
    tick();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 in_en in reset", 32'(scan_in_en), 1);
    @(negedge clk); rst = 1'b0;
    tick();
    chk("R1 in_en", 32'(scan_in_en), 1);
    chk("R1 out_en", 32'(scan_out_en), 1);
    chk("R1 key_sel", 32'(key_load_sel), 0);
    chk("R1 key", 32'(eng_key), 0);

    // R9 shift a mirror key in while open
    shift_byte(8'hA5);
    chk("R9 mirror key", 32'(eng_key), 32'hA5);
    chk("R9 eng_si msb", 32'(eng_si), 1);
    @(negedge clk); scan_shift = 1'b1; #1;
    chk("R9 eng_shift", 32'(eng_shift), 1);
    drive_idle();

    // vector table: mirror shifting in rows 3 does not matter for checks
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      ir_value = VEC[v][11:8]; ir_update = VEC[v][7];
      scan_shift = VEC[v][6]; scan_si = VEC[v][5]; eng_so = VEC[v][4];
      tick();
      chk("R2 R3 R4 in_en", 32'(scan_in_en), 32'(VEC[v][3]));
      chk("R2 R3 R4 out_en", 32'(scan_out_en), 32'(VEC[v][2]));
      chk("R2 R6 key_sel", 32'(key_load_sel), 32'(VEC[v][1]));
      chk("R7 scan_so", 32'(scan_so), 32'(VEC[v][0]));
    end
    chk("R6 secret key", 32'(eng_key), 32'h3C);

    // R8 scan attempts while locked are ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      scan_shift = 1'b1; scan_si = i[0]; eng_so = 1'b1;
      ir_value = 4'(i); ir_update = 1'b1;
      tick();
      chk("R8 eng_si", 32'(eng_si), 0);
      chk("R8 eng_shift", 32'(eng_shift), 0);
      chk("R7 scan_so blocked", 32'(scan_so), 0);
      chk("R4 still locked", 32'(key_load_sel), 1);
    end
    drive_idle();

    // R5 reset restores access
    do_reset();
    chk("R5 in_en", 32'(scan_in_en), 1);
    chk("R5 key_sel", 32'(key_load_sel), 0);
    eng_so = 1'b1; #1;
    chk("R7 open passthrough", 32'(scan_so), 1);
    shift_byte(8'h5A);
    chk("R5 R9 mirror reload", 32'(eng_key), 32'h5A);

    // R6 same-edge key switch
    @(negedge clk); ir_value = 4'b1010; ir_update = 1'b1;
    #1;
    chk("R6 key before edge", 32'(eng_key), 32'h5A);
    tick();
    chk("R6 key after edge", 32'(eng_key), 32'h3C);
    chk("R6 in_en after edge", 32'(scan_in_en), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule